// File: doc/BRIEF.md
# Four-Channel Step-Scaled PWM Generator

This block drives four independent pulse-width modulated pins. Each channel reads an 8-bit frequency word made of a 2-bit range step and a 6-bit count. The output frequency is (count+1) × 0.5 Hz × 4^step, which covers 0.5 Hz to 2048 Hz. An 8-bit duty word sets the high time in units of 1/256 of the period. A polarity bit swaps the two phases, and an enable bit turns the channel on or off. The configuration comes straight from a register file and can change at any time. Changes act at once and never reset the running counters, so a period that is in progress can mix the old and new settings.

The timing reference is a single-cycle `tick` strobe that runs at the rate `BASE_TICK_HZ`. Each channel splits its period into 256 duty slots. A phase accumulator of modulus `MOD = BASE_TICK_HZ/128` gains `(count+1) << (2*step)` on every tick, and each wrap of the accumulator moves the slot counter on by one. The default rate is 1 048 576 Hz. A testbench can lower it to 524 288 Hz (MOD = 4096) so that the fastest setting advances one slot per tick. MOD must be at least 4096 and must be a multiple of 4096 for the periods to come out exact.

Each channel has a two-state controller. `CH_IDLE` holds both counters at zero and drives the pin low. `CH_RUN` advances the counters on each tick. Transition START (`CH_IDLE`→`CH_RUN`) is taken when enable is high. Transition STOP (`CH_RUN`→`CH_IDLE`) is taken when enable is low.

Top module: `quad_pwm_gen`

## Requirements
- R1: After reset every pin is low and every channel is in `CH_IDLE`.
- R2: The frequency word holds the step in bits 7:6 and the count in bits 5:0. With a tick on every clock, one period lasts exactly 256·MOD/((count+1)·4^step) clocks when that divides evenly.
- R3: The active phase lasts (duty+1) of the 256 slots and the idle phase lasts the remaining 255−duty slots. A duty of 255 keeps the pin active without a break, and a duty of 0 still gives one active slot.
- R4: When polarity is 1 on a running channel, the pin is low in the active phase and high in the idle phase.
- R5: If enable is low in one cycle, the pin is low in the next cycle, whatever the polarity, and it stays low while enable stays low.
- R6: Enable is sampled at a clock edge. When it is sampled high on an idle channel, the slot counter starts at 0 and the active phase appears from the following cycle. That phase lasts duty+1 slots.
- R7: New duty or polarity values change the pin in the same cycle. A frequency, duty or polarity change does not reset the slot counter or the accumulator.
- R8: The counters advance only in cycles where `tick` is high, and they advance by at most one slot per tick. With `tick` held low the pin is frozen.
- R9: Each channel runs only from its own configuration bits, so a change to one channel does not alter the timing of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Base timing strobe at BASE_TICK_HZ |
| freq_i | input | NCH×8 | Per-channel frequency words: step in bits 7:6, count in bits 5:0 |
| duty_i | input | NCH×8 | Per-channel duty words, active slots = duty+1 |
| pol_i | input | NCH | Per-channel polarity: 1 swaps the phases |
| en_i | input | NCH | Per-channel enable |
| pwm_o | output | NCH | PWM pins |

## Verification
The assertions assume that `tick` and the configuration inputs are synchronous to `clk`. They also assume that MOD is at least 4096, so that one tick can never carry the accumulator past more than one slot. The bench keeps within these assumptions. It changes the inputs only at falling edges and uses MOD = 4096. It chooses counts whose (count+1) is a power of two, so every expected high and low length is an exact integer given by the formulas.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_t;

    localparam int CFG_W  = 8;
    localparam int SLOT_W = 8;
    localparam int INC_W  = 13;
    localparam int STEP_HI = 7;
    localparam int STEP_LO = 6;
    localparam int CNT_HI  = 5;
endpackage

// File: rtl/quad_pwm_rate.sv
module quad_pwm_rate
    import quad_pwm_pkg::*;
(
    input  logic [CFG_W-1:0] freq_word,
    output logic [INC_W-1:0] phase_inc
);
    logic [1:0]       step;
    logic [INC_W-1:0] base;

    always_comb begin
        step      = freq_word[STEP_HI:STEP_LO];
        base      = INC_W'(freq_word[CNT_HI:0]) + INC_W'(1);
        phase_inc = base << {step, 1'b0};
    end
endmodule

// File: rtl/quad_pwm_chan.sv
module quad_pwm_chan
    import quad_pwm_pkg::*;
#(
    parameter int MOD = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CFG_W-1:0]  freq_word,
    input  logic [SLOT_W-1:0] duty,
    input  logic              pol,
    input  logic              en,
    output logic              pwm
);
    localparam int ACC_W = $clog2(MOD) + 1;

    ch_state_t         state, state_nx;
    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  acc_sum;
    logic [SLOT_W-1:0] slot;
    logic [INC_W-1:0]  inc;
    logic              run;

    quad_pwm_rate u_rate (
        .freq_word (freq_word),
        .phase_inc (inc)
    );

    assign run = (state == CH_RUN);

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: if (en)  state_nx = CH_RUN;
            CH_RUN:  if (!en) state_nx = CH_IDLE;
            default:          state_nx = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    assign acc_sum = acc + ACC_W'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            slot <= '0;
        end else if (!run || !en) begin
            acc  <= '0;
            slot <= '0;
        end else if (tick) begin
            if (acc_sum >= ACC_W'(MOD)) begin
                acc  <= acc_sum - ACC_W'(MOD);
                slot <= slot + SLOT_W'(1);
            end else begin
                acc  <= acc_sum;
            end
        end
    end

    always_comb begin
        pwm = 1'b0;
        unique case (state)
            CH_IDLE: pwm = 1'b0;
            CH_RUN:  pwm = (slot <= duty) ^ pol;
            default: pwm = 1'b0;
        endcase
    end

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm);  // R5
    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && en) |=> (slot == '0 && acc == '0));  // R6
    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && en) |=> (pwm ^ pol));  // R6
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en && !tick) |=> ($stable(slot) && $stable(acc)));  // R8
    AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en) |=> (slot == $past(slot) || slot == $past(slot) + 8'd1));  // R8
    AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        acc < ACC_W'(MOD));  // R2
endmodule

// File: rtl/quad_pwm_gen.sv
module quad_pwm_gen
    import quad_pwm_pkg::*;
#(
    parameter int NCH          = 4,
    parameter int BASE_TICK_HZ = 1048576
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic [NCH-1:0][CFG_W-1:0]   freq_i,
    input  logic [NCH-1:0][SLOT_W-1:0]  duty_i,
    input  logic [NCH-1:0]              pol_i,
    input  logic [NCH-1:0]              en_i,
    output logic [NCH-1:0]              pwm_o
);
    localparam int MOD = BASE_TICK_HZ / 128;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        quad_pwm_chan #(.MOD(MOD)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .freq_word (freq_i[c]),
            .duty      (duty_i[c]),
            .pol       (pol_i[c]),
            .en        (en_i[c]),
            .pwm       (pwm_o[c])
        );
    end

    AST_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pwm_o == '0));  // R1
endmodule

// File: tb/quad_pwm_gen_test.sv
module quad_pwm_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 tick = 1'b1;
    logic [NCH-1:0][7:0]  freq = '0;
    logic [NCH-1:0][7:0]  duty = '0;
    logic [NCH-1:0]       pol = '0;
    logic [NCH-1:0]       en = '0;
    logic [NCH-1:0]       pwm;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_pwm_gen #(.NCH(NCH), .BASE_TICK_HZ(524288)) uut (
        .clk (clk), .rst_n (rst_n), .tick (tick),
        .freq_i (freq), .duty_i (duty), .pol_i (pol), .en_i (en),
        .pwm_o (pwm)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic smp();
        @(negedge clk); #1;
    endtask

    // Finds a rising edge of the pin, then counts one high and one low run.
    task automatic measure(input int ch, output int hi, output int lo);
        logic prev;
        int guard = 0;
        hi = 0; lo = 0;
        smp(); prev = pwm[ch];
        forever begin
            smp();
            guard++;
            if ((!prev && pwm[ch]) || guard > 40000) break;
            prev = pwm[ch];
        end
        hi = 1;
        forever begin smp(); if (!pwm[ch] || hi > 40000) break; hi++; end
        lo = 1;
        forever begin smp(); if (pwm[ch] || lo > 40000) break; lo++; end
    endtask

    task automatic t_reset();
        smp();
        check("R1 pins low in reset", int'(pwm), 0);
        @(negedge clk); rst_n = 1'b1;
        smp(); smp();
        check("R1 pins low after reset", int'(pwm), 0);
    endtask

    task automatic t_steps();
        int hi, lo;
        @(negedge clk);
        freq[0] = {2'd0, 6'd63}; duty[0] = 8'd63;
        freq[1] = {2'd1, 6'd63}; duty[1] = 8'd31;
        freq[2] = {2'd2, 6'd31}; duty[2] = 8'd0;
        freq[3] = {2'd3, 6'd63}; duty[3] = 8'd200;
        en = 4'hF;
        measure(3, hi, lo);
        check("R2 step3 high", hi, 201); check("R3 step3 low", lo, 55);
        measure(2, hi, lo);
        check("R3 step2 duty0 high", hi, 8); check("R2 step2 low", lo, 2040);
        measure(1, hi, lo);
        check("R2 step1 high", hi, 512); check("R2 step1 low", lo, 3584);
        measure(0, hi, lo);
        check("R2 step0 high", hi, 4096); check("R2 step0 low", lo, 12288);
    endtask

    task automatic t_polarity();
        int hi, lo;
        @(negedge clk); pol[3] = 1'b1;
        measure(3, hi, lo);
        check("R4 inverted high", hi, 55); check("R4 inverted low", lo, 201);
        @(negedge clk); pol[3] = 1'b0;
    endtask

    task automatic t_disable();
        int ones = 0;
        @(negedge clk); pol[3] = 1'b1; en[3] = 1'b0;
        smp();
        for (int i = 0; i < 400; i++) begin smp(); ones += int'(pwm[3]); end
        check("R5 disabled inverted stays low", ones, 0);
        @(negedge clk); pol[3] = 1'b0;
    endtask

    task automatic t_enable();
        int hi = 0;
        @(negedge clk); duty[3] = 8'd9; en[3] = 1'b1;
        smp();
        check("R6 active right after enable", int'(pwm[3]), 1);
        hi = 1;
        forever begin smp(); if (!pwm[3] || hi > 400) break; hi++; end
        check("R6 first active phase length", hi, 10);
    endtask

    task automatic t_full_duty();
        int zeros = 0;
        @(negedge clk); duty[3] = 8'd255;
        for (int i = 0; i < 600; i++) begin smp(); zeros += int'(!pwm[3]); end
        check("R3 duty 255 never idle", zeros, 0);
    endtask

    task automatic t_live_change();
        int hi, lo;
        logic prev;
        @(negedge clk); duty[3] = 8'd200;
        smp(); prev = pwm[3];
        for (int g = 0; g < 600; g++) begin
            smp();
            if (!prev && pwm[3]) break;
            prev = pwm[3];
        end
        for (int i = 0; i < 99; i++) smp();
        check("R7 high mid phase", int'(pwm[3]), 1);
        @(negedge clk); duty[3] = 8'd50; #1;
        check("R7 drops at once on duty change", int'(pwm[3]), 0);
        measure(3, hi, lo);
        check("R7 new duty high", hi, 51); check("R7 new duty low", lo, 205);
    endtask

    task automatic t_tick_freeze();
        logic prev;
        int changes = 0;
        smp(); prev = pwm[3];
        for (int g = 0; g < 600; g++) begin
            smp();
            if (!prev && pwm[3]) break;
            prev = pwm[3];
        end
        for (int i = 0; i < 5; i++) smp();
        @(negedge clk); tick = 1'b0;
        for (int i = 0; i < 300; i++) begin smp(); changes += int'(!pwm[3]); end
        check("R8 frozen without tick", changes, 0);
        @(negedge clk); tick = 1'b1;
    endtask

    task automatic t_independent();
        int hi, lo;
        @(negedge clk); en[3] = 1'b0; duty[3] = 8'd0; freq[3] = 8'd0;
        measure(2, hi, lo);
        check("R9 ch2 unaffected high", hi, 8); check("R9 ch2 unaffected low", lo, 2040);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_steps();
        t_polarity();
        t_disable();
        t_enable();
        t_full_duty();
        t_live_change();
        t_tick_freeze();
        t_independent();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule